// File: doc/BRIEF.md
# AXI write response rule monitor

This block is a passive, synthesizable checker. It sits beside an AXI write path and only observes it: the address channel (valid, ready, ID, exclusive marker), the write data channel (valid, ready, ID, last-beat marker) and the write response channel (valid, ready, ID, two-bit response code). It never drives any of these channels. Every rule it enforces has its own bit in an error vector. Each bit is sticky until reset, so a short violation deep in a long run still shows at the end.

Each channel carries one valid/ready pair. A transfer (a "handshake") happens on a rising clock edge where both valid and ready are high. While valid is high and ready is low, the source is being back-pressured. The rules of this monitor require the source to hold its ID, its response code and its valid during that back-pressure. The monitor keeps small per-ID counters for accepted addresses and accepted final data beats, plus one exclusive flag per ID. It uses them to judge the order of each response handshake.

Hard violations set bits of `err_vec`, and `err_any` is their OR. Recommendation-class violations set bits of `rec_vec` and stay out of `err_any`. A one-cycle `eot` pulse asks the monitor to confirm that no accepted address still lacks its response.

Top module: `wresp_monitor`

## Requirements
- R1: While a response is stalled (valid high, ready low at one edge), a different response ID at the next edge sets `err_vec[0]`.
- R2: While a response is stalled, a different response code at the next edge sets `err_vec[1]`.
- R3: Response valid going low at the edge after a stalled edge sets `err_vec[2]`.
- R4: Response valid high at the first clock edge after `rst_n` goes high sets `err_vec[3]`.
- R5: A response handshake for an ID with no earlier accepted final data beat (`wd_last`) for that ID sets `err_vec[4]`. A final beat accepted at the same edge does not count.
- R6: A response handshake for an ID with no earlier accepted address for that ID sets `rec_vec[0]`.
- R7: A response handshake with code 2'b01 (exclusive okay) sets `err_vec[5]` unless the ID has a pending exclusive address. That flag is set by an address handshake with `wa_excl` high and cleared by the next response handshake for the ID.
- R8: A response that is valid without ready at more than `MAX_WAITS` consecutive edges sets `rec_vec[1]` at the edge where it is stalled for the `MAX_WAITS`+1-th time.
- R9: An `eot` pulse sampled while any ID holds an accepted address with no response handshake yet sets `err_vec[6]`. With nothing outstanding, the pulse sets nothing.
- R10: An address or final-beat counter that would exceed 2^`CNT_W`-1 for an ID sets `err_vec[7]` and saturates.
- R11: All flags are visible in the cycle after the edge that samples the violation. They stay set until `rst_n` is low. Reset clears them and all counters. `err_any` is the OR of `err_vec` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; all checks masked while low |
| wa_vld | input | 1 | Address channel valid |
| wa_rdy | input | 1 | Address channel ready |
| wa_id | input | ID_W | Address channel ID |
| wa_excl | input | 1 | Address marks an exclusive write |
| wd_vld | input | 1 | Write data valid |
| wd_rdy | input | 1 | Write data ready |
| wd_id | input | ID_W | Write data ID |
| wd_last | input | 1 | Final beat of a burst |
| rsp_vld | input | 1 | Response valid |
| rsp_rdy | input | 1 | Response ready (master side) |
| rsp_id | input | ID_W | Response ID |
| rsp_code | input | 2 | Response code; 2'b01 is exclusive okay |
| eot | input | 1 | End-of-test pulse |
| err_vec | output | 8 | Sticky hard-error bits, one per rule |
| rec_vec | output | 2 | Sticky recommendation bits |
| err_any | output | 1 | OR of all hard-error bits |

## Verification
The hardest state to reach from the ports is the reset-cycle rule. The response valid must already be high at the very first edge after reset release. The stimulus therefore holds valid high through the whole reset and then completes a handshake with nothing tracked, so three rules fire together. Counter saturation and the exact wait limit are also hard to reach. The bench shrinks the counters and the wait limit through parameters, then drives a run of addresses that lands exactly on the limit, and stall lengths of exactly the limit and one beyond it.

// File: rtl/wresp_mon_pkg.sv
package wresp_mon_pkg;
  localparam int N_HARD = 8;
  localparam int N_REC  = 2;

  // hard-error bit positions
  localparam int E_ID_HOLD   = 0;
  localparam int E_CODE_HOLD = 1;
  localparam int E_VLD_DROP  = 2;
  localparam int E_RST_VLD   = 3;
  localparam int E_NO_LAST   = 4;
  localparam int E_BAD_EXCL  = 5;
  localparam int E_UNMATCHED = 6;
  localparam int E_OVERFLOW  = 7;

  // recommendation bit positions
  localparam int W_NO_ADDR  = 0;
  localparam int W_SLOW_RDY = 1;

  localparam logic [1:0] RSP_EXCL_OK = 2'b01;
endpackage

// File: rtl/wresp_id_tracker.sv
module wresp_id_tracker
  import wresp_mon_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_fire,
  input  logic [ID_W-1:0] a_id,
  input  logic            a_excl,
  input  logic            l_fire,
  input  logic [ID_W-1:0] l_id,
  input  logic            r_fire,
  input  logic [ID_W-1:0] r_id,
  input  logic [1:0]      r_code,
  input  logic            eot,
  output logic            flg_no_last,
  output logic            flg_no_addr,
  output logic            flg_bad_excl,
  output logic            flg_ovf,
  output logic            flg_unmatched
);
  localparam int             N_ID  = 1 << ID_W;
  localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};

  logic [N_ID-1:0] no_addr, no_last, excl_set, a_ovf, l_ovf;

  for (genvar g = 0; g < N_ID; g++) begin : g_slot
    logic [CNT_W-1:0] a_cnt, l_cnt;
    logic             ex_q;
    logic             hit_a, hit_l, hit_r, dec_a, dec_l;

    assign hit_a = a_fire && (a_id == ID_W'(g));
    assign hit_l = l_fire && (l_id == ID_W'(g));
    assign hit_r = r_fire && (r_id == ID_W'(g));
    assign dec_a = hit_r && (a_cnt != '0);
    assign dec_l = hit_r && (l_cnt != '0);

    assign a_ovf[g]    = hit_a && !dec_a && (a_cnt == C_MAX);
    assign l_ovf[g]    = hit_l && !dec_l && (l_cnt == C_MAX);
    assign no_addr[g]  = (a_cnt == '0);
    assign no_last[g]  = (l_cnt == '0);
    assign excl_set[g] = ex_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_cnt <= '0;
        l_cnt <= '0;
        ex_q  <= 1'b0;
      end else begin
        if (hit_a && !dec_a && !a_ovf[g]) a_cnt <= a_cnt + CNT_W'(1);
        else if (dec_a && !hit_a)         a_cnt <= a_cnt - CNT_W'(1);
        if (hit_l && !dec_l && !l_ovf[g]) l_cnt <= l_cnt + CNT_W'(1);
        else if (dec_l && !hit_l)         l_cnt <= l_cnt - CNT_W'(1);
        if (hit_a && a_excl) ex_q <= 1'b1;
        else if (hit_r)      ex_q <= 1'b0;
      end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (a_cnt == C_MAX && hit_a && !dec_a) |=> (a_cnt == C_MAX)); // R10
  end

  assign flg_no_last   = r_fire && no_last[r_id];
  assign flg_no_addr   = r_fire && no_addr[r_id];
  assign flg_bad_excl  = r_fire && (r_code == RSP_EXCL_OK) && !excl_set[r_id];
  assign flg_ovf       = (|a_ovf) || (|l_ovf);
  assign flg_unmatched = eot && !(&no_addr);
endmodule

// File: rtl/wresp_hs_checker.sv
module wresp_hs_checker
  import wresp_mon_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int MAX_WAITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld,
  input  logic            rdy,
  input  logic [ID_W-1:0] id,
  input  logic [1:0]      code,
  output logic            flg_id_hold,
  output logic            flg_code_hold,
  output logic            flg_drop,
  output logic            flg_rst_vld,
  output logic            flg_slow
);
  localparam int             WC_W  = $clog2(MAX_WAITS + 2);
  localparam logic [WC_W-1:0] W_LIM = WC_W'(MAX_WAITS);

  logic            first_q, hold_q, stall;
  logic [ID_W-1:0] id_q;
  logic [1:0]      code_q;
  logic [WC_W-1:0] wcnt_q;

  assign stall = vld && !rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      hold_q  <= 1'b0;
      id_q    <= '0;
      code_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      first_q <= 1'b0;
      hold_q  <= stall;
      id_q    <= id;
      code_q  <= code;
      if (!stall)              wcnt_q <= '0;
      else if (wcnt_q != W_LIM) wcnt_q <= wcnt_q + WC_W'(1);
    end
  end

  assign flg_rst_vld   = first_q && vld;
  assign flg_drop      = hold_q && !vld;
  assign flg_id_hold   = hold_q && vld && (id != id_q);
  assign flg_code_hold = hold_q && vld && (code != code_q);
  assign flg_slow      = stall && (wcnt_q == W_LIM);
endmodule

// File: rtl/wresp_monitor.sv
module wresp_monitor
  import wresp_mon_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int CNT_W     = 4,
  parameter int MAX_WAITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_vld,
  input  logic              wa_rdy,
  input  logic [ID_W-1:0]   wa_id,
  input  logic              wa_excl,
  input  logic              wd_vld,
  input  logic              wd_rdy,
  input  logic [ID_W-1:0]   wd_id,
  input  logic              wd_last,
  input  logic              rsp_vld,
  input  logic              rsp_rdy,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [1:0]        rsp_code,
  input  logic              eot,
  output logic [N_HARD-1:0] err_vec,
  output logic [N_REC-1:0]  rec_vec,
  output logic              err_any
);
  logic [N_HARD-1:0] hard_now, err_q;
  logic [N_REC-1:0]  rec_now, rec_q;
  logic              a_fire, l_fire, r_fire;

  assign a_fire = wa_vld && wa_rdy;
  assign l_fire = wd_vld && wd_rdy && wd_last;
  assign r_fire = rsp_vld && rsp_rdy;

  wresp_hs_checker #(.ID_W(ID_W), .MAX_WAITS(MAX_WAITS)) u_hs (
    .clk          (clk),
    .rst_n        (rst_n),
    .vld          (rsp_vld),
    .rdy          (rsp_rdy),
    .id           (rsp_id),
    .code         (rsp_code),
    .flg_id_hold  (hard_now[E_ID_HOLD]),
    .flg_code_hold(hard_now[E_CODE_HOLD]),
    .flg_drop     (hard_now[E_VLD_DROP]),
    .flg_rst_vld  (hard_now[E_RST_VLD]),
    .flg_slow     (rec_now[W_SLOW_RDY])
  );

  wresp_id_tracker #(.ID_W(ID_W), .CNT_W(CNT_W)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .a_fire       (a_fire),
    .a_id         (wa_id),
    .a_excl       (wa_excl),
    .l_fire       (l_fire),
    .l_id         (wd_id),
    .r_fire       (r_fire),
    .r_id         (rsp_id),
    .r_code       (rsp_code),
    .eot          (eot),
    .flg_no_last  (hard_now[E_NO_LAST]),
    .flg_no_addr  (rec_now[W_NO_ADDR]),
    .flg_bad_excl (hard_now[E_BAD_EXCL]),
    .flg_ovf      (hard_now[E_OVERFLOW]),
    .flg_unmatched(hard_now[E_UNMATCHED])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      rec_q <= '0;
    end else begin
      err_q <= err_q | hard_now;
      rec_q <= rec_q | rec_now;
    end
  end

  assign err_vec = err_q;
  assign rec_vec = rec_q;
  assign err_any = |err_q;

  AST_STICKY_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_vec & $past(err_vec)) == $past(err_vec))); // R11
  AST_RST_VLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_vec[E_RST_VLD]) |-> $past(rsp_vld)); // R4
  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_vec[E_VLD_DROP]) |-> !$past(rsp_vld)); // R3
  AST_EXCL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_vec[E_BAD_EXCL]) |-> $past(rsp_vld && rsp_rdy && rsp_code == RSP_EXCL_OK)); // R7
  AST_SLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_vec[W_SLOW_RDY]) |-> $past(rsp_vld && !rsp_rdy)); // R8
  AST_EOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_vec[E_UNMATCHED]) |-> $past(eot)); // R9
endmodule

// File: tb/wresp_monitor_tb.sv
`timescale 1ns/1ps
module wresp_monitor_tb_top;
  localparam int IDW  = 2;
  localparam int CW   = 3;
  localparam int MAXW = 4;
  localparam int NID  = 1 << IDW;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wa_vld = 0, wa_rdy = 0, wa_excl = 0;
  logic [IDW-1:0] wa_id = '0, wd_id = '0, rsp_id = '0;
  logic wd_vld = 0, wd_rdy = 0, wd_last = 0;
  logic rsp_vld = 0, rsp_rdy = 0, eot = 0;
  logic [1:0] rsp_code = '0;
  logic [7:0] err_vec;
  logic [1:0] rec_vec;
  logic err_any;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wresp_monitor #(.ID_W(IDW), .CNT_W(CW), .MAX_WAITS(MAXW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wa_vld(wa_vld), .wa_rdy(wa_rdy), .wa_id(wa_id), .wa_excl(wa_excl),
    .wd_vld(wd_vld), .wd_rdy(wd_rdy), .wd_id(wd_id), .wd_last(wd_last),
    .rsp_vld(rsp_vld), .rsp_rdy(rsp_rdy), .rsp_id(rsp_id), .rsp_code(rsp_code),
    .eot(eot), .err_vec(err_vec), .rec_vec(rec_vec), .err_any(err_any)
  );

  // ---------------- behavioural reference model ----------------
  int m_acnt [NID];
  int m_lcnt [NID];
  bit m_excl [NID];
  bit m_first, m_hold;
  logic [IDW-1:0] m_pid;
  logic [1:0] m_pcode;
  int m_wcnt;
  logic [7:0] m_err;
  logic [1:0] m_rec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NID; g++) begin
        m_acnt[g] = 0; m_lcnt[g] = 0; m_excl[g] = 0;
      end
      m_first = 1; m_hold = 0; m_wcnt = 0; m_pid = '0; m_pcode = '0;
      m_err = '0; m_rec = '0;
    end else begin
      bit rf;
      rf = rsp_vld && rsp_rdy;
      if (m_first && rsp_vld) m_err[3] = 1;
      m_first = 0;
      if (m_hold) begin
        if (!rsp_vld) m_err[2] = 1;
        else begin
          if (rsp_id != m_pid) m_err[0] = 1;
          if (rsp_code != m_pcode) m_err[1] = 1;
        end
      end
      if (rsp_vld && !rsp_rdy) begin
        if (m_wcnt >= MAXW) m_rec[1] = 1;
        m_wcnt++;
      end else m_wcnt = 0;
      if (rf) begin
        if (m_lcnt[rsp_id] == 0) m_err[4] = 1;
        if (m_acnt[rsp_id] == 0) m_rec[0] = 1;
        if (rsp_code == 2'b01 && !m_excl[rsp_id]) m_err[5] = 1;
      end
      if (eot) begin
        for (int g = 0; g < NID; g++) if (m_acnt[g] != 0) m_err[6] = 1;
      end
      for (int g = 0; g < NID; g++) begin
        int ia, il, da, dl, na, nl;
        ia = (wa_vld && wa_rdy && wa_id == g) ? 1 : 0;
        il = (wd_vld && wd_rdy && wd_last && wd_id == g) ? 1 : 0;
        da = (rf && rsp_id == g && m_acnt[g] > 0) ? 1 : 0;
        dl = (rf && rsp_id == g && m_lcnt[g] > 0) ? 1 : 0;
        na = m_acnt[g] + ia - da;
        nl = m_lcnt[g] + il - dl;
        if (na > CMAX) begin m_err[7] = 1; na = CMAX; end
        if (nl > CMAX) begin m_err[7] = 1; nl = CMAX; end
        if (ia == 1 && wa_excl) m_excl[g] = 1;
        else if (rf && rsp_id == g) m_excl[g] = 0;
        m_acnt[g] = na; m_lcnt[g] = nl;
      end
      m_hold = rsp_vld && !rsp_rdy;
      m_pid = rsp_id; m_pcode = rsp_code;
    end
  end

  function automatic string ereq(int b);
    case (b)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R7";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (err_vec !== m_err || rec_vec !== m_rec || err_any !== (|m_err)) begin
        n_bad++;
        for (int b = 0; b < 8; b++)
          if (err_vec[b] !== m_err[b])
            $display("FAIL %s t=%0t err_vec[%0d]=%b exp=%b", ereq(b), $time, b, err_vec[b], m_err[b]);
        if (rec_vec[0] !== m_rec[0])
          $display("FAIL R6 t=%0t rec_vec[0]=%b exp=%b", $time, rec_vec[0], m_rec[0]);
        if (rec_vec[1] !== m_rec[1])
          $display("FAIL R8 t=%0t rec_vec[1]=%b exp=%b", $time, rec_vec[1], m_rec[1]);
        if (err_any !== (|m_err))
          $display("FAIL R11 t=%0t err_any=%b exp=%b", $time, err_any, |m_err);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr();
    wa_vld = 0; wa_rdy = 0; wa_excl = 0; wa_id = '0;
    wd_vld = 0; wd_rdy = 0; wd_last = 0; wd_id = '0;
    rsp_vld = 0; rsp_rdy = 0; rsp_id = '0; rsp_code = '0; eot = 0;
  endtask

  task automatic do_reset();
    clr();
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
    cyc();
  endtask

  task automatic addr(input int id, input bit ex);
    wa_vld = 1; wa_rdy = 1; wa_id = IDW'(id); wa_excl = ex;
    cyc();
    wa_vld = 0; wa_rdy = 0; wa_excl = 0;
  endtask

  task automatic data(input int id, input int beats);
    wd_vld = 1; wd_rdy = 0; wd_id = IDW'(id); wd_last = 0;
    cyc(); // one back-pressured beat
    for (int i = 0; i < beats; i++) begin
      wd_rdy = 1; wd_last = (i == beats - 1);
      cyc();
    end
    wd_vld = 0; wd_rdy = 0; wd_last = 0;
  endtask

  task automatic resp(input int id, input logic [1:0] code, input int stall);
    rsp_vld = 1; rsp_rdy = 0; rsp_id = IDW'(id); rsp_code = code;
    for (int i = 0; i < stall; i++) cyc();
    rsp_rdy = 1;
    cyc();
    rsp_vld = 0; rsp_rdy = 0;
  endtask

  task automatic chk(input logic [7:0] e, input logic [1:0] r, input string tag);
    n_vec++;
    if (err_vec !== e || rec_vec !== r || err_any !== (|e)) begin
      n_bad++;
      $display("FAIL %s err_vec=%h exp=%h rec_vec=%h exp=%h err_any=%b exp=%b",
               tag, err_vec, e, rec_vec, r, err_any, |e);
    end
  endtask

  // ---------------- directed scenarios ----------------
  initial begin
    clr();
    cyc(); cyc();
    rst_n = 1; cyc();
    chk(8'h00, 2'b00, "R11 reset state");

    // clean write with a stalled response, then eot: nothing flagged
    addr(1, 0); data(1, 3); resp(1, 2'b00, 2);
    eot = 1; cyc(); eot = 0; cyc();
    chk(8'h00, 2'b00, "R1 R2 R5 R9 clean transaction");

    // R1: ID changes during stall
    do_reset();
    addr(2, 0); data(2, 1);
    rsp_vld = 1; rsp_rdy = 0; rsp_id = 2'd2; cyc();
    rsp_id = 2'd3; cyc();
    rsp_id = 2'd2; rsp_rdy = 1; cyc();
    clr(); cyc();
    chk(8'h01, 2'b00, "R1 id change under stall");

    // R2: code changes during stall
    do_reset();
    addr(0, 0); data(0, 1);
    rsp_vld = 1; rsp_rdy = 0; rsp_id = 2'd0; rsp_code = 2'b00; cyc();
    rsp_code = 2'b10; cyc();
    rsp_code = 2'b00; rsp_rdy = 1; cyc();
    clr(); cyc();
    chk(8'h02, 2'b00, "R2 code change under stall");

    // R3: valid dropped while stalled
    do_reset();
    addr(0, 0); data(0, 1);
    rsp_vld = 1; rsp_rdy = 0; cyc();
    rsp_vld = 0; cyc(); cyc();
    chk(8'h04, 2'b00, "R3 valid dropped");

    // R4: valid high through reset and the first cycle after it
    clr(); rst_n = 0; rsp_vld = 1; rsp_rdy = 0; cyc(); cyc();
    rst_n = 1; cyc();
    rsp_rdy = 1; cyc();
    clr(); cyc();
    chk(8'h18, 2'b01, "R4 valid in first cycle (plus R5 R6)");

    // R5: response after address but with no final beat
    do_reset();
    addr(1, 0);
    wd_vld = 1; wd_rdy = 1; wd_id = 2'd1; wd_last = 0; cyc();
    wd_vld = 0; wd_rdy = 0;
    resp(1, 2'b00, 0); cyc();
    chk(8'h10, 2'b00, "R5 response before final beat");

    // R5 boundary: final beat and response accepted at the same edge
    do_reset();
    addr(1, 0);
    wd_vld = 1; wd_rdy = 1; wd_id = 2'd1; wd_last = 1;
    rsp_vld = 1; rsp_rdy = 1; rsp_id = 2'd1; cyc();
    clr(); cyc();
    chk(8'h10, 2'b00, "R5 same-edge final beat");

    // R6: response before address; recommendation only, err_any stays low
    do_reset();
    data(3, 1); resp(3, 2'b00, 0);
    eot = 1; cyc(); eot = 0; cyc();
    chk(8'h00, 2'b01, "R6 response before address, R9 nothing outstanding");

    // R7: exclusive okay legal after exclusive address, illegal otherwise
    do_reset();
    addr(2, 1); data(2, 1); resp(2, 2'b01, 0); cyc();
    chk(8'h00, 2'b00, "R7 exclusive okay allowed");
    addr(2, 0); data(2, 1); resp(2, 2'b01, 0); cyc();
    chk(8'h20, 2'b00, "R7 exclusive okay without exclusive address");

    // R8: stall of exactly MAXW edges is fine, MAXW+1 is flagged
    do_reset();
    addr(0, 0); data(0, 1); resp(0, 2'b00, MAXW); cyc();
    chk(8'h00, 2'b00, "R8 stall at limit");
    addr(0, 0); data(0, 1); resp(0, 2'b00, MAXW + 1); cyc();
    chk(8'h00, 2'b10, "R8 stall beyond limit");

    // R9: eot with an outstanding address
    do_reset();
    addr(3, 0);
    eot = 1; cyc(); eot = 0; cyc();
    chk(8'h40, 2'b00, "R9 unmatched at eot");

    // R10: counter saturation
    do_reset();
    for (int i = 0; i < CMAX; i++) addr(1, 0);
    cyc();
    chk(8'h00, 2'b00, "R10 counter at max");
    addr(1, 0); cyc();
    chk(8'h80, 2'b00, "R10 counter overflow");

    // R11: flags stay set through clean traffic, cleared by reset
    data(1, 1); resp(1, 2'b00, 1); cyc(); cyc();
    chk(8'h80, 2'b00, "R11 sticky");
    do_reset();
    chk(8'h00, 2'b00, "R11 cleared by reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule